// File: doc/BRIEF.md
# Reset Boot-Mode Strap Sampler

This block chooses, each time the chip leaves reset, between starting the normal program and starting the embedded serial-link boot loader. The choice comes from the level on one strap pin. Three reset-cause levels feed the block: the external reset pin, the power-on reset of the always-powered domain, and a combined line for every other source. The block runs from the free-running, uncalibrated high-frequency oscillator.

While any reset is active, and for a fixed startup delay after the last reset input falls, the block forces the strap pad to input mode with its pull-up on. It also holds the core in reset. On the final cycle of the delay it takes the synchronized strap level. In the next cycle it does three things together: it releases the core, drops the pad override and raises a done flag.

The strap is honoured only when the reset episode included a pin reset or an always-on power-on reset. Any other episode ends in normal boot. The result is held until the next reset.

Top module: `boot_strap_sampler`

## Requirements
- R1: While any of `pin_rst`, `aon_por`, `other_rst` is high, `strap_pullup_en`, `strap_force_input` and `core_rst_hold` are 1 and `boot_done` is 0.
- R2: `boot_done` rises after exactly STARTUP_CYCLES (default 512) rising clock edges with all reset inputs low, and not before.
- R3: In the cycle `boot_done` rises, `strap_pullup_en`, `strap_force_input` and `core_rst_hold` all fall to 0.
- R4: After an episode that included `pin_rst` or `aon_por`, a low strap level gives `boot_serial` = 1 (serial boot loader).
- R5: After such an episode, a high strap level gives `boot_serial` = 0 (normal boot).
- R6: After an episode in which only `other_rst` was high, `boot_serial` is 0 whatever the strap level.
- R7: An episode in which `other_rst` and a qualifying cause are both high counts as qualifying.
- R8: If any reset input rises during the startup delay, the delay restarts from zero once all inputs are low again.
- R9: Once `boot_done` is 1, `boot_done` and `boot_serial` hold their values until the next reset, whatever the strap pin does.
- R10: `boot_serial` is 0 during reset and throughout the startup delay.
- R11: The strap passes through a two-flop synchronizer. The level that decides is the one present at the rising edge two edges before the last edge of the delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Uncalibrated high-frequency oscillator clock |
| pin_rst | input | 1 | External reset-pin reset, active high |
| aon_por | input | 1 | Always-on domain power-on reset, active high |
| other_rst | input | 1 | Any other reset source (watchdog, software, low-voltage), active high |
| strap_pad_in | input | 1 | Level read from the strap pad |
| strap_pullup_en | output | 1 | Forces the strap pad pull-up on |
| strap_force_input | output | 1 | Forces the strap pad to input mode |
| core_rst_hold | output | 1 | Holds the processor core in reset |
| boot_serial | output | 1 | 1 = serial boot loader, 0 = normal program |
| boot_done | output | 1 | Boot decision made and core released |

## Verification
The pad override, the core hold and `boot_done` follow the reset inputs in the same cycle. They change only on the 512th rising edge after release. The bench therefore drives on falling edges, counts falling edges from release, and checks at the 511th that nothing has moved yet and at the 512th that everything has moved. The boot selection appears at that same edge. It reflects the pad level as seen two rising edges earlier, so the synchronizer tests move the strap just after the 509th and just after the 510th edge and expect opposite results.

// File: rtl/boot_strap_pkg.sv
package boot_strap_pkg;

    localparam int unsigned DEFAULT_STARTUP_CYCLES = 512;
    localparam int unsigned DEFAULT_SYNC_STAGES    = 2;

    typedef enum logic {
        PH_HOLD = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

    typedef enum logic {
        BOOT_NORMAL = 1'b0,
        BOOT_SERIAL = 1'b1
    } boot_sel_e;

    typedef struct packed {
        logic pin;
        logic aon_por;
        logic other;
    } rst_cause_t;

    function automatic logic cause_any(rst_cause_t c);
        return c.pin | c.aon_por | c.other;
    endfunction

    function automatic logic cause_honours_strap(rst_cause_t c);
        return c.pin | c.aon_por;
    endfunction

    function automatic boot_sel_e pick_boot(logic honour, logic strap_level);
        return (honour && !strap_level) ? BOOT_SERIAL : BOOT_NORMAL;
    endfunction

endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= 1'b1;
                else     chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/reset_cause_tracker.sv
module reset_cause_tracker
    import boot_strap_pkg::*;
(
    input  logic       clk,
    input  rst_cause_t cause,
    output logic       in_rst,
    output logic       honour
);
    logic in_rst_q;
    logic honour_q;

    assign in_rst = cause_any(cause);

    always_ff @(posedge clk) begin
        in_rst_q <= in_rst;
        if (in_rst) begin
            // first cycle of an episode forgets the previous episode
            honour_q <= (in_rst_q & honour_q) | cause_honours_strap(cause);
        end
    end

    assign honour = honour_q;
endmodule

// File: rtl/startup_timer.sv
module startup_timer
    import boot_strap_pkg::*;
#(
    parameter int unsigned CYCLES = DEFAULT_STARTUP_CYCLES
) (
    input  logic clk,
    input  logic rst,
    output logic expire,
    output logic running
);
    localparam int unsigned CW   = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt;
    phase_e        ph;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            ph  <= PH_HOLD;
        end else if (ph == PH_HOLD) begin
            cnt <= cnt + 1'b1;
            if (cnt == LAST) ph <= PH_RUN;
        end
    end

    assign running = (ph == PH_HOLD) && !rst;
    assign expire  = running && (cnt == LAST);
endmodule

// File: rtl/boot_strap_sampler.sv
module boot_strap_sampler
    import boot_strap_pkg::*;
#(
    parameter int unsigned STARTUP_CYCLES = DEFAULT_STARTUP_CYCLES,
    parameter int unsigned SYNC_STAGES    = DEFAULT_SYNC_STAGES
) (
    input  logic clk,
    input  logic pin_rst,
    input  logic aon_por,
    input  logic other_rst,
    input  logic strap_pad_in,
    output logic strap_pullup_en,
    output logic strap_force_input,
    output logic core_rst_hold,
    output logic boot_serial,
    output logic boot_done
);
    rst_cause_t cause;
    logic       in_rst;
    logic       honour;
    logic       strap_s;
    logic       expire;
    logic       running;
    boot_sel_e  boot_q;
    logic       done_q;

    assign cause = '{pin: pin_rst, aon_por: aon_por, other: other_rst};

    reset_cause_tracker u_cause (
        .clk    (clk),
        .cause  (cause),
        .in_rst (in_rst),
        .honour (honour)
    );

    strap_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (in_rst),
        .d   (strap_pad_in),
        .q   (strap_s)
    );

    startup_timer #(.CYCLES(STARTUP_CYCLES)) u_timer (
        .clk     (clk),
        .rst     (in_rst),
        .expire  (expire),
        .running (running)
    );

    always_ff @(posedge clk) begin
        if (in_rst) begin
            boot_q <= BOOT_NORMAL;
            done_q <= 1'b0;
        end else if (expire) begin
            boot_q <= pick_boot(honour, strap_s);
            done_q <= 1'b1;
        end
    end

    assign strap_pullup_en   = in_rst | ~done_q;
    assign strap_force_input = in_rst | ~done_q;
    assign core_rst_hold     = in_rst | ~done_q;
    assign boot_serial       = (boot_q == BOOT_SERIAL);
    assign boot_done         = done_q & ~in_rst;
endmodule

// File: rtl/boot_strap_checker.sv
module boot_strap_checker #(
    parameter int unsigned STARTUP_CYCLES = 512
) (
    input logic clk,
    input logic pin_rst,
    input logic aon_por,
    input logic other_rst,
    input logic strap_pullup_en,
    input logic strap_force_input,
    input logic core_rst_hold,
    input logic boot_serial,
    input logic boot_done
);
    localparam int unsigned CW = $clog2(STARTUP_CYCLES + 2);

    logic          in_rst;
    logic [CW-1:0] ck_cnt;

    assign in_rst = pin_rst | aon_por | other_rst;

    always_ff @(posedge clk) begin
        if (in_rst)
            ck_cnt <= '0;
        else if (!boot_done && ck_cnt <= CW'(STARTUP_CYCLES))
            ck_cnt <= ck_cnt + 1'b1;
    end

    assert_hold_in_reset_R1: assert property (@(posedge clk)
        in_rst |-> strap_pullup_en && strap_force_input && core_rst_hold && !boot_done);

    assert_delay_length_R2: assert property (@(posedge clk) disable iff (in_rst)
        $rose(boot_done) |-> ck_cnt == CW'(STARTUP_CYCLES));

    assert_not_early_R2: assert property (@(posedge clk) disable iff (in_rst)
        !boot_done |-> ck_cnt <= CW'(STARTUP_CYCLES));

    assert_release_together_R3: assert property (@(posedge clk) disable iff (in_rst)
        $rose(boot_done) |-> !strap_pullup_en && !strap_force_input && !core_rst_hold);

    assert_result_held_R9: assert property (@(posedge clk) disable iff (in_rst)
        boot_done |=> boot_done && $stable(boot_serial));

    assert_normal_before_done_R10: assert property (@(posedge clk) disable iff (in_rst)
        !boot_done |-> !boot_serial);
endmodule

bind boot_strap_sampler boot_strap_checker #(.STARTUP_CYCLES(STARTUP_CYCLES)) i_chk (
    .clk               (clk),
    .pin_rst           (pin_rst),
    .aon_por           (aon_por),
    .other_rst         (other_rst),
    .strap_pullup_en   (strap_pullup_en),
    .strap_force_input (strap_force_input),
    .core_rst_hold     (core_rst_hold),
    .boot_serial       (boot_serial),
    .boot_done         (boot_done)
);

// File: tb/test_boot_strap_sampler.sv
module test_boot_strap_sampler;
    localparam int unsigned DLY = 512;
    localparam int NVEC = 7;
    // {pin_rst, aon_por, other_rst, strap level, expected boot_serial}
    localparam logic [4:0] VEC [NVEC] = '{
        5'b100_0_1,   // R4 pin reset, strap low
        5'b100_1_0,   // R5 pin reset, strap high
        5'b010_0_1,   // R4 power-on, strap low
        5'b010_1_0,   // R5 power-on, strap high
        5'b001_0_0,   // R6 other only, strap low
        5'b001_1_0,   // R6 other only, strap high
        5'b101_0_1    // R7 other plus pin, strap low
    };

    logic clk = 1'b0;
    logic pin_rst = 1'b0, aon_por = 1'b1, other_rst = 1'b0, strap = 1'b1;
    logic pu, fi, hold, serial, done;
    int total = 0, bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    boot_strap_sampler i_boot_strap_sampler (
        .clk(clk), .pin_rst(pin_rst), .aon_por(aon_por), .other_rst(other_rst),
        .strap_pad_in(strap), .strap_pullup_en(pu), .strap_force_input(fi),
        .core_rst_hold(hold), .boot_serial(serial), .boot_done(done)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset(input logic p, input logic a, input logic o);
        @(negedge clk);
        pin_rst = p; aon_por = a; other_rst = o;
        wait_neg(4);
        chk("R1 override in reset", {pu, fi, hold, done}, 4'b1110);
        chk("R10 normal in reset", serial, 1'b0);
        pin_rst = 0; aon_por = 0; other_rst = 0;
    endtask

    initial begin
        wait_neg(3);
        chk("R1 reset state", {pu, fi, hold, done}, 4'b1110);
        chk("R10 reset state serial", serial, 1'b0);
        aon_por = 0;

        for (int v = 0; v < NVEC; v++) begin
            strap = VEC[v][1];
            do_reset(VEC[v][4], VEC[v][3], VEC[v][2]);
            wait_neg(DLY - 1);
            chk("R2 not done at 511", {done, hold}, 2'b01);
            chk("R10 normal during delay", serial, 1'b0);
            wait_neg(1);
            chk("R2 done at 512", done, 1'b1);
            chk("R3 release together", {pu, fi, hold}, 3'b000);
            chk("R4 R5 R6 R7 boot select", serial, VEC[v][0]);
        end

        // R9: strap toggling after done has no effect
        for (int i = 0; i < 20; i++) begin
            strap = ~strap;
            @(negedge clk);
            chk("R9 held after done", {done, serial}, 2'b11);
        end

        // R8: restart of the delay
        strap = 0;
        do_reset(1, 0, 0);
        wait_neg(300);
        chk("R8 not done mid delay", done, 1'b0);
        pin_rst = 1; wait_neg(2); pin_rst = 0;
        wait_neg(DLY - 1);
        chk("R8 restarted count not done", done, 1'b0);
        wait_neg(1);
        chk("R8 done after full restart", {done, serial}, 2'b11);

        // R11: change just after edge 510 -> old (low) level decides
        strap = 0;
        do_reset(1, 0, 0);
        wait_neg(DLY - 2); strap = 1;
        wait_neg(2);
        chk("R11 late change ignored", {done, serial}, 2'b11);

        // R11: change just after edge 509 -> new (high) level decides
        strap = 0;
        do_reset(1, 0, 0);
        wait_neg(DLY - 3); strap = 1;
        wait_neg(3);
        chk("R11 earlier change taken", {done, serial}, 2'b10);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule